// File: doc/BRIEF.md
# ATA PIO Host Timing Engine

This block sits on the host side of a parallel ATA channel and runs one programmed-I/O register access at a time. A request supplies the direction, whether the command block or the control block is addressed, a 3-bit register offset and, for writes, a 16-bit word. The engine drives the two active-low chip selects, the three device address lines and the active-low read or write strobe. It drives the data bus for writes and captures it for reads. Each access returns a one-cycle response that carries the read word and an error flag.

All timing is counted in system clocks. A package function turns the nanosecond limits of PIO modes 0 to 4 (cycle time 600, 383, 240, 180 and 120 ns, together with address setup, strobe width and strobe recovery) into clock counts for the configured clock period. A generate loop builds the five-entry table from that function. A mode register chooses the entry, and the engine copies it at the moment a request is accepted, so a mode written during an access applies from the next access. In modes 3 and 4 the drive may hold the ready line low to stretch the strobe, and a timeout ends a stretch that lasts too long. In modes 0 to 2 the ready line is ignored.

The sequencer has four states. IDLE moves to SETUP when a request is accepted. SETUP moves to STROBE when its count expires. STROBE moves to RECOVER when its count expires and the drive is ready, or when the stretch times out. RECOVER moves back to IDLE when its count expires and issues the response in that same final clock.

Top module: `ata_pio_host`

## Requirements
- R1: Reset puts the engine in IDLE with `req_ready`=1, both chip selects and both strobes high, `ata_dd_oe`=0, `rsp_valid`=0 and the mode register at 0.
- R2: Address and chip select are valid for exactly the setup count before the strobe falls. At 4 ns per clock this is 18, 13, 8, 8 and 7 clocks for modes 0 to 4.
- R3: With the drive ready, the strobe stays low for exactly 42, 32, 25, 20 and 18 clocks in modes 0 to 4.
- R4: The chip select stays active for the full cycle, which is 150, 96, 60, 46 and 32 clocks in modes 0 to 4. The recovery after the strobe rises is the larger of the minimum recovery and the remainder of the cycle time, and is never less than one clock.
- R5: During an access exactly one chip select is low: `ata_cs0_n` when `req_sel_ctrl`=0 and `ata_cs1_n` when it is 1. `ata_da` equals the request offset from setup through recovery. Both chip selects are high in IDLE.
- R6: A read pulses the strobe `ata_dior_n` and returns the value that `ata_dd_in` held in the last strobe-low clock. That value appears on `rsp_rdata` during the single clock in which `rsp_valid`=1, which is the last recovery clock. `req_ready` rises in the next clock.
- R7: A write pulses only `ata_diow_n`. It holds `ata_dd_oe`=1 with `ata_dd_out` equal to the request word from setup through the end of recovery, and returns `ata_dd_oe` to 0 in IDLE.
- R8: In modes 3 and 4, while `ata_iordy`=0 after the strobe count has expired, the strobe stays low. It rises on the first clock edge at which `ata_iordy`=1.
- R9: In modes 0 to 2, `ata_iordy` has no effect on any timing.
- R10: In modes 3 and 4, a stretch that reaches TMO_CLKS clocks (default 300) ends the strobe, so the strobe is low for (strobe count - 1 + TMO_CLKS) clocks. The access completes through recovery with `rsp_err`=1. Accesses that do not time out give `rsp_err`=0.
- R11: A mode write made while an access is in progress does not change that access. It takes effect from the next accepted request.
- R12: A mode write with a value above 4 is ignored, and the previous mode stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode register write enable |
| mode_wdata | input | 3 | PIO mode to program (0 to 4) |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Engine idle, request accepted |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_sel_ctrl | input | 1 | 1 = control block (CS1), 0 = command block (CS0) |
| req_addr | input | 3 | Register offset within the block |
| req_wdata | input | 16 | Word to write |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Word captured by a read |
| rsp_err | output | 1 | Access ended by IORDY timeout |
| ata_cs0_n | output | 1 | Command-block chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_iordy | input | 1 | Drive ready, low stretches the strobe |
| ata_dd_in | input | 16 | Data bus from the drive |
| ata_dd_out | output | 16 | Data bus to the drive |
| ata_dd_oe | output | 1 | Data bus output enable |

## Verification
The hardest situations to reach from the ports are a mode write landing in the middle of an access and an IORDY stretch that ends on an exact clock or runs out the timeout. The bench watches the strobe clock by clock. It drives the mode write after a chosen number of strobe-low clocks and raises `ata_iordy` after a chosen number. In the timeout case it leaves `ata_iordy` low for the whole access. It also changes `ata_dd_in` as soon as the strobe rises, which shows that the engine captured the word in the last strobe-low clock and not afterwards.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    localparam int NUM_MODES = 5;
    localparam int CNT_W     = 8;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recover;
    } pio_tim_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER
    } seq_state_t;

    function automatic int ceil_clk(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // Nanosecond limits per PIO mode, converted to clock counts.
    function automatic pio_tim_t pio_calc(input int mode, input int clk_ns);
        int cyc_ns, set_ns, act_ns, rec_ns;
        int c_set, c_act, c_rem, c_rec;
        pio_tim_t r;
        unique case (mode)
            0:       begin cyc_ns = 600; set_ns = 70; act_ns = 165; rec_ns = 0;  end
            1:       begin cyc_ns = 383; set_ns = 50; act_ns = 125; rec_ns = 0;  end
            2:       begin cyc_ns = 240; set_ns = 30; act_ns = 100; rec_ns = 0;  end
            3:       begin cyc_ns = 180; set_ns = 30; act_ns = 80;  rec_ns = 70; end
            default: begin cyc_ns = 120; set_ns = 25; act_ns = 70;  rec_ns = 25; end
        endcase
        c_set = ceil_clk(set_ns, clk_ns);
        c_act = ceil_clk(act_ns, clk_ns);
        c_rem = ceil_clk(cyc_ns, clk_ns) - c_set - c_act;
        c_rec = ceil_clk(rec_ns, clk_ns);
        if (c_rem > c_rec) c_rec = c_rem;
        if (c_rec < 1)     c_rec = 1;
        if (c_set < 1)     c_set = 1;
        if (c_act < 1)     c_act = 1;
        r.setup   = CNT_W'(c_set);
        r.active  = CNT_W'(c_act);
        r.recover = CNT_W'(c_rec);
        return r;
    endfunction

endpackage

// File: rtl/ata_pio_mode_reg.sv
module ata_pio_mode_reg
    import ata_pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [2:0] wdata,
    output logic [2:0] mode_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 3'd0;
        end else if (we && (int'(wdata) < NUM_MODES)) begin
            mode_q <= wdata;
        end
    end

    assert_mode_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mode_q) < NUM_MODES);

    assert_bad_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(wdata) >= NUM_MODES) |=> $stable(mode_q));

endmodule

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
    import ata_pio_pkg::*;
#(
    parameter int CLK_NS = 4
) (
    input  logic [2:0] mode,
    output pio_tim_t   tim
);

    pio_tim_t tbl [NUM_MODES];

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        assign tbl[g] = pio_calc(g, CLK_NS);
    end

    always_comb begin
        if (int'(mode) < NUM_MODES) tim = tbl[mode];
        else                        tim = tbl[NUM_MODES-1];
    end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int TMO_CLKS = 300,
    parameter int FAST_MIN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  mode_in,
    input  pio_tim_t    tim,
    output logic [2:0]  look_mode,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic        req_sel_ctrl,
    input  logic [2:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic        rsp_err,
    output logic        ata_cs0_n,
    output logic        ata_cs1_n,
    output logic [2:0]  ata_da,
    output logic        ata_dior_n,
    output logic        ata_diow_n,
    input  logic        ata_iordy,
    input  logic [15:0] ata_dd_in,
    output logic [15:0] ata_dd_out,
    output logic        ata_dd_oe
);

    localparam int WAIT_W = $clog2(TMO_CLKS + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(TMO_CLKS - 1);

    seq_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [WAIT_W-1:0] wcnt;
    logic [2:0]        cyc_mode;
    logic              wr_q, ctrl_q, err_q;
    logic [2:0]        addr_q;
    logic [15:0]       wdata_q, rdata_q;
    logic              use_iordy, busy;

    assign use_iordy = int'(cyc_mode) >= FAST_MIN;
    assign look_mode = (state == ST_IDLE) ? mode_in : cyc_mode;

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            wcnt     <= '0;
            cyc_mode <= 3'd0;
            wr_q     <= 1'b0;
            ctrl_q   <= 1'b0;
            addr_q   <= 3'd0;
            wdata_q  <= 16'd0;
            rdata_q  <= 16'd0;
            err_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state    <= ST_SETUP;
                        cnt      <= tim.setup - 1'b1;
                        wcnt     <= '0;
                        cyc_mode <= mode_in;
                        wr_q     <= req_write;
                        ctrl_q   <= req_sel_ctrl;
                        addr_q   <= req_addr;
                        wdata_q  <= req_wdata;
                        err_q    <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        state <= ST_STROBE;
                        cnt   <= tim.active - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (!use_iordy || ata_iordy || wcnt == WAIT_LAST) begin
                        state <= ST_RECOVER;
                        cnt   <= tim.recover - 1'b1;
                        if (!wr_q) rdata_q <= ata_dd_in;
                        if (use_iordy && !ata_iordy) err_q <= 1'b1;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_RECOVER: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        req_ready  = (state == ST_IDLE);
        ata_cs0_n  = !(busy && !ctrl_q);
        ata_cs1_n  = !(busy && ctrl_q);
        ata_da     = busy ? addr_q : 3'd0;
        ata_dior_n = !((state == ST_STROBE) && !wr_q);
        ata_diow_n = !((state == ST_STROBE) && wr_q);
        ata_dd_oe  = busy && wr_q;
        ata_dd_out = wdata_q;
        rsp_valid  = (state == ST_RECOVER) && (cnt == '0);
        rsp_rdata  = rdata_q;
        rsp_err    = err_q;
    end

    assert_one_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ata_cs0_n, ~ata_cs1_n}));

    assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_dior_n && !ata_diow_n));

    assert_setup_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ata_dior_n & ata_diow_n) |-> $past(!(ata_cs0_n & ata_cs1_n)));

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ata_dior_n & ata_diow_n) |-> !(ata_cs0_n & ata_cs1_n));

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ata_cs0_n & ata_cs1_n) && $past(!(ata_cs0_n & ata_cs1_n))) |-> $stable(ata_da));

    assert_wdata_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ata_dd_oe && $past(ata_dd_oe)) |-> $stable(ata_dd_out));

    assert_slow_no_stretch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && !use_iordy) |-> (wcnt == '0));

    assert_stretch_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE) |-> (int'(wcnt) < TMO_CLKS));

    assert_rsp_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

endmodule

// File: rtl/ata_pio_host.sv
module ata_pio_host
    import ata_pio_pkg::*;
#(
    parameter int CLK_NS   = 4,
    parameter int TMO_CLKS = 300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_we,
    input  logic [2:0]  mode_wdata,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic        req_sel_ctrl,
    input  logic [2:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic        rsp_err,
    output logic        ata_cs0_n,
    output logic        ata_cs1_n,
    output logic [2:0]  ata_da,
    output logic        ata_dior_n,
    output logic        ata_diow_n,
    input  logic        ata_iordy,
    input  logic [15:0] ata_dd_in,
    output logic [15:0] ata_dd_out,
    output logic        ata_dd_oe
);

    logic [2:0] pend_mode;
    logic [2:0] look_mode;
    pio_tim_t   tim;

    ata_pio_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mode_we),
        .wdata  (mode_wdata),
        .mode_q (pend_mode)
    );

    ata_pio_timing #(.CLK_NS(CLK_NS)) u_tim (
        .mode (look_mode),
        .tim  (tim)
    );

    ata_pio_seq #(.TMO_CLKS(TMO_CLKS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_in      (pend_mode),
        .tim          (tim),
        .look_mode    (look_mode),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_sel_ctrl (req_sel_ctrl),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .rsp_err      (rsp_err),
        .ata_cs0_n    (ata_cs0_n),
        .ata_cs1_n    (ata_cs1_n),
        .ata_da       (ata_da),
        .ata_dior_n   (ata_dior_n),
        .ata_diow_n   (ata_diow_n),
        .ata_iordy    (ata_iordy),
        .ata_dd_in    (ata_dd_in),
        .ata_dd_out   (ata_dd_out),
        .ata_dd_oe    (ata_dd_oe)
    );

endmodule

// File: tb/ata_pio_host_test.sv
`timescale 1ns/1ps
module ata_pio_host_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [2:0]  mode_wdata = 3'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_sel_ctrl = 1'b0;
    logic [2:0]  req_addr = 3'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        rsp_err;
    logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
    logic [2:0]  ata_da;
    logic        ata_iordy = 1'b1;
    logic [15:0] ata_dd_in = 16'd0;
    logic [15:0] ata_dd_out;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    ata_pio_host uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_sel_ctrl(req_sel_ctrl), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
        .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_iordy(ata_iordy),
        .ata_dd_in(ata_dd_in), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe)
    );

    // mode, setup clocks, strobe clocks, total select clocks
    localparam int VEC [5][4] = '{
        '{0, 18, 42, 150},
        '{1, 13, 32,  96},
        '{2,  8, 25,  60},
        '{3,  8, 20,  46},
        '{4,  7, 18,  32}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode_we = 1'b1;
        mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    int n_set, n_stb, n_tot;
    logic [15:0] got;
    logic got_err, sel_ok, oe_ok, post_ok;

    task automatic run(input logic wr, input logic c1, input logic [2:0] a,
                       input logic [15:0] wd, input logic [15:0] rd,
                       input int rel, input int dm_at, input logic [2:0] dm_val);
        bit seen, done, act, stb;
        int guard;
        n_set = 0; n_stb = 0; n_tot = 0; got = 16'd0; got_err = 1'b0;
        sel_ok = 1'b1; oe_ok = 1'b1; seen = 1'b0; done = 1'b0; guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_sel_ctrl = c1;
        req_addr = a; req_wdata = wd; ata_dd_in = rd;
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
            req_valid = 1'b0;
            act = !(ata_cs0_n && ata_cs1_n);
            stb = wr ? !ata_diow_n : !ata_dior_n;
            if (wr ? !ata_dior_n : !ata_diow_n) sel_ok = 1'b0;
            if (act && !seen && !stb) n_set++;
            if (stb) begin
                n_stb++;
                seen = 1'b1;
                if (rel > 0 && n_stb == rel) ata_iordy = 1'b1;
            end
            if (seen && !stb) ata_dd_in = ~rd;
            if (dm_at > 0 && n_stb == dm_at && stb) begin
                mode_we = 1'b1; mode_wdata = dm_val;
            end else begin
                mode_we = 1'b0;
            end
            if (act) begin
                n_tot++;
                if (c1 ? !(ata_cs1_n == 1'b0 && ata_cs0_n == 1'b1)
                       : !(ata_cs0_n == 1'b0 && ata_cs1_n == 1'b1)) sel_ok = 1'b0;
                if (ata_da != a) sel_ok = 1'b0;
                if (wr ? !(ata_dd_oe && ata_dd_out == wd) : ata_dd_oe) oe_ok = 1'b0;
            end
            if (rsp_valid) begin
                got = rsp_rdata; got_err = rsp_err; done = 1'b1;
            end
        end
        if (!done) chk(1'b0, "watchdog-cycle", guard, 0);
        @(negedge clk);
        post_ok = !rsp_valid && req_ready && !ata_dd_oe && ata_cs0_n && ata_cs1_n;
        ata_iordy = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(req_ready && ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n
            && !ata_dd_oe && !rsp_valid, "R1 reset outputs", 0, 1);
        rst_n = 1'b1;
        // R1: default mode 0 timing right after reset
        run(1'b0, 1'b0, 3'd7, 16'h0, 16'h1357, 0, 0, 3'd0);
        chk(n_stb == 42, "R1 default mode0 strobe", n_stb, 42);

        // Table walk: every mode, one read and one write
        for (int i = 0; i < 5; i++) begin
            set_mode(3'(VEC[i][0]));
            for (int w = 0; w < 2; w++) begin
                logic [15:0] rdv;
                logic [15:0] wdv;
                logic [2:0] ad;
                rdv = 16'hA000 + 16'(i * 16 + w);
                wdv = 16'h5A00 + 16'(i * 3 + w);
                ad = (w == 0) ? 3'(i) : 3'd6;
                run(1'(w), 1'(w), ad, wdv, rdv, 0, 0, 3'd0);
                chk(n_set == VEC[i][1], "R2 setup clocks", n_set, VEC[i][1]);
                chk(n_stb == VEC[i][2], "R3 strobe clocks", n_stb, VEC[i][2]);
                chk(n_tot == VEC[i][3], "R4 cycle clocks", n_tot, VEC[i][3]);
                chk(sel_ok, "R5 select and address", 0, 1);
                chk(oe_ok, "R7 data drive", 0, 1);
                chk(post_ok, "R6 single response then idle", 0, 1);
                chk(!got_err, "R10 no error", got_err, 0);
                if (w == 0) chk(got == rdv, "R6 read data", got, rdv);
            end
        end

        // R8: stretch in mode 3, release after 40 strobe clocks
        set_mode(3'd3);
        ata_iordy = 1'b0;
        run(1'b0, 1'b0, 3'd0, 16'h0, 16'hBEEF, 40, 0, 3'd0);
        chk(n_stb == 40, "R8 stretched strobe", n_stb, 40);
        chk(n_tot == 66, "R8 stretched cycle", n_tot, 66);
        chk(got == 16'hBEEF && !got_err, "R8 stretched read data", got, 16'hBEEF);

        // R9: IORDY low ignored in mode 2
        set_mode(3'd2);
        ata_iordy = 1'b0;
        run(1'b1, 1'b0, 3'd0, 16'h1234, 16'h0, 0, 0, 3'd0);
        chk(n_stb == 25, "R9 mode2 ignores iordy", n_stb, 25);
        chk(!got_err, "R9 no error", got_err, 0);

        // R10: timeout in mode 4
        set_mode(3'd4);
        ata_iordy = 1'b0;
        run(1'b0, 1'b1, 3'd6, 16'h0, 16'h4242, 0, 0, 3'd0);
        chk(n_stb == 317, "R10 timeout strobe", n_stb, 317);
        chk(n_tot == 331, "R10 timeout cycle", n_tot, 331);
        chk(got_err, "R10 error flag", got_err, 1);
        run(1'b0, 1'b1, 3'd6, 16'h0, 16'h4243, 0, 0, 3'd0);
        chk(!got_err && n_stb == 18, "R10 error clears next access", n_stb, 18);

        // R11: mode write in mid-access is deferred
        set_mode(3'd0);
        run(1'b0, 1'b0, 3'd1, 16'h0, 16'h0F0F, 0, 5, 3'd4);
        chk(n_stb == 42, "R11 current access keeps mode0", n_stb, 42);
        run(1'b0, 1'b0, 3'd1, 16'h0, 16'h0F0F, 0, 0, 3'd0);
        chk(n_stb == 18, "R11 next access uses mode4", n_stb, 18);

        // R12: illegal mode value ignored
        set_mode(3'd2);
        set_mode(3'd7);
        run(1'b0, 1'b0, 3'd2, 16'h0, 16'h0, 0, 0, 3'd0);
        chk(n_stb == 25, "R12 mode7 ignored", n_stb, 25);
        set_mode(3'd5);
        run(1'b1, 1'b0, 3'd2, 16'h7777, 16'h0, 0, 0, 3'd0);
        chk(n_stb == 25, "R12 mode5 ignored", n_stb, 25);

        // R1: reset returns mode to 0
        set_mode(3'd4);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(req_ready && ata_cs0_n && ata_cs1_n && !ata_dd_oe, "R1 reset again", 0, 1);
        rst_n = 1'b1;
        run(1'b0, 1'b0, 3'd0, 16'h0, 16'h0, 0, 0, 3'd0);
        chk(n_stb == 42, "R1 reset mode0", n_stb, 42);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule